// File: doc/BRIEF.md
# Per-Pin Timing Edge Formatter

This block is a single tester channel. It takes a stream of test vectors and, for each one, produces a drive waveform on the pin or senses the pin and compares it with an expected level. It runs on a fine tick clock in which one tick is the timing resolution: 1 ns in the intended use. One vector occupies a programmable number of ticks. Every vector names one of four stored time sets. A time set gives the tick at which the driver turns on, the tick at which it turns off, and the tick at which the sensed level is strobed. Because the set is chosen per vector, edges can move from one vector to the next inside a burst, independent of any other channel.

The drive waveform is shaped by a channel format: non-return-to-zero, return-to-zero or return-to-one. A direction bit in each vector chooses drive or sense. In sense mode the driver is released for the whole vector. A compare at the strobe tick raises a one-tick fail pulse and a sticky fail flag; a mask bit in the vector suppresses the compare. The time-set table is written through a plain register write port.

Vectors enter on a valid/ready stream. `vec_ready` is high while the channel is idle and on the last tick of the running vector, and low on every other tick. A vector is taken on a clock edge where both `vec_valid` and `vec_ready` are high, and its tick 0 is the cycle after that edge. A source that holds `vec_valid` with the next vector gets back-to-back vectors with no idle tick. A source that drops `vec_valid` leaves the channel idle until the next vector. While `vec_ready` is low, the vector fields must stay stable and `vec_valid` must not be withdrawn. The table, `period_i` and `fmt_i` are meant to be changed only while the channel is idle.

Top module: `pin_edge_formatter`

## Requirements
- R1: The vector length in ticks is `period_i`. A value below 10 is treated as 10. A vector runs ticks 0 to length-1, advancing one tick per clock.
- R2: With `fmt_i` = 0 or 3 (non-return-to-zero), a drive vector outputs its data bit from the drive-on tick to the end of the vector. Before the drive-on tick it outputs the data bit of the last drive vector (0 after reset).
- R3: With `fmt_i` = 1 (return-to-zero), a drive vector outputs its data bit on ticks t with drive-on <= t < drive-off, and 0 on all other ticks.
- R4: With `fmt_i` = 2 (return-to-one), a drive vector outputs its data bit on ticks t with drive-on <= t < drive-off, and 1 on all other ticks.
- R5: `pin_oe` is 1 for every tick of a vector with `vec_drive` = 1. It is 0 for every tick of a vector with `vec_drive` = 0, and 0 while idle.
- R6: Four time sets are stored. `cfg_we` writes `cfg_val` into set `cfg_set`, at field `cfg_edge` (0 = drive-on, 1 = drive-off, 2 = strobe). Each vector uses the set named by its own `vec_set`, so consecutive vectors may use different sets.
- R7: `vec_ready` is 1 when idle or on the last tick, and 0 otherwise. An accepted vector starts at tick 0 on the next cycle. Back-to-back vectors leave no gap.
- R8: On the strobe tick of an unmasked vector, `pin_in` is compared with `vec_exp`. On a mismatch, `fail_pulse` is 1 for exactly the following cycle. `pin_in` on any other tick has no effect.
- R9: `fail_sticky` sets together with `fail_pulse` and holds. `fail_clr` clears it on the next edge, unless a fail is raised on that same edge.
- R10: Any stored edge value that is at least the vector length acts as length-1.
- R11: A vector with `vec_mask` = 1 never raises `fail_pulse` and leaves `fail_sticky` unchanged.
- R12: After reset the channel is idle: `vec_ready` = 1, `pin_oe` = 0, `pin_out` = 0, both fail outputs 0, and every time-set field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | TICK_W | Vector length in ticks |
| fmt_i | input | 2 | Drive format: 0 NRZ, 1 RZ, 2 R1, 3 NRZ |
| cfg_we | input | 1 | Time-set write strobe |
| cfg_set | input | SET_W | Time set to write |
| cfg_edge | input | 2 | Field to write: 0 drive-on, 1 drive-off, 2 strobe |
| cfg_val | input | TICK_W | Edge tick value |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be taken this cycle |
| vec_data | input | 1 | Drive data bit |
| vec_drive | input | 1 | 1 = drive, 0 = sense |
| vec_exp | input | 1 | Expected sensed level |
| vec_mask | input | 1 | 1 = skip compare |
| vec_set | input | SET_W | Time set for this vector |
| pin_in | input | 1 | Sensed pin level |
| pin_out | output | 1 | Drive level |
| pin_oe | output | 1 | Driver enable |
| fail_clr | input | 1 | Clear sticky fail |
| fail_pulse | output | 1 | One-cycle compare fail |
| fail_sticky | output | 1 | Latched compare fail |

## Verification
The waveform is checked tick by tick for data 1 and data 0 under each of the three formats. Alternating data in non-return-to-zero separates a held previous bit from a fresh bit before the drive-on edge. Back-to-back vectors that switch between two time sets show that edges follow the set named by each vector rather than the first one. A sensed level that is wrong everywhere except at the strobe tick, then a level wrong only at the strobe tick, shows the compare samples one tick only. Masked mismatches, out-of-range edges and a too-short period probe the clamping and masking corners.

// File: rtl/pef_pkg.sv
`timescale 1ns/1ps
package pef_pkg;
  localparam logic [1:0] FMT_NRZ = 2'd0;
  localparam logic [1:0] FMT_RZ  = 2'd1;
  localparam logic [1:0] FMT_R1  = 2'd2;

  localparam logic [1:0] EDGE_ON     = 2'd0;
  localparam logic [1:0] EDGE_OFF    = 2'd1;
  localparam logic [1:0] EDGE_STROBE = 2'd2;

  typedef struct packed {
    logic data;
    logic drive;
    logic exp_v;
    logic mask;
  } vec_t;
endpackage

// File: rtl/pef_tset_table.sv
`timescale 1ns/1ps
module pef_tset_table
  import pef_pkg::*;
#(
  parameter int TICK_W   = 8,
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [1:0]        wr_edge,
  input  logic [TICK_W-1:0] wr_val,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TICK_W-1:0] per_eff,
  output logic [TICK_W-1:0] on_o,
  output logic [TICK_W-1:0] off_o,
  output logic [TICK_W-1:0] strobe_o
);
  localparam int NUM_EDGES = 3;

  logic [TICK_W-1:0] tab_q [NUM_SETS][NUM_EDGES];
  logic [TICK_W-1:0] eff   [NUM_EDGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int e = 0; e < NUM_EDGES; e++)
          tab_q[s][e] <= '0;
    end else if (wr_en && wr_edge <= EDGE_STROBE) begin
      tab_q[wr_set][wr_edge] <= wr_val;
    end
  end

  // Each edge of the selected set is limited to the last tick of the vector.
  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_clamp
    always_comb begin
      if (tab_q[rd_set][e] >= per_eff) eff[e] = per_eff - TICK_W'(1);
      else                             eff[e] = tab_q[rd_set][e];
    end
  end

  assign on_o     = eff[EDGE_ON];
  assign off_o    = eff[EDGE_OFF];
  assign strobe_o = eff[EDGE_STROBE];
endmodule

// File: rtl/pef_tick_seq.sv
`timescale 1ns/1ps
module pef_tick_seq
  import pef_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int SET_W      = 2,
  parameter int MIN_PERIOD = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] period_i,
  input  logic              in_valid,
  input  vec_t              in_vec,
  input  logic [SET_W-1:0]  in_set,
  output logic              in_ready,
  output logic [TICK_W-1:0] tick_o,
  output logic              active_o,
  output vec_t              cur_o,
  output logic [SET_W-1:0]  cur_set_o,
  output logic [TICK_W-1:0] per_eff_o
);
  localparam logic [TICK_W-1:0] MIN_P = TICK_W'(MIN_PERIOD);

  logic [TICK_W-1:0] tick_q;
  logic              active_q;
  logic              last;
  vec_t              cur_q;
  logic [SET_W-1:0]  set_q;

  assign per_eff_o = (period_i < MIN_P) ? MIN_P : period_i;
  assign last      = tick_q >= per_eff_o - TICK_W'(1);
  assign in_ready  = !active_q || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      active_q <= 1'b0;
      cur_q    <= '0;
      set_q    <= '0;
    end else if (in_valid && in_ready) begin
      tick_q   <= '0;
      active_q <= 1'b1;
      cur_q    <= in_vec;
      set_q    <= in_set;
    end else if (active_q) begin
      if (last) begin
        tick_q   <= '0;
        active_q <= 1'b0;
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end

  assign tick_o    = tick_q;
  assign active_o  = active_q;
  assign cur_o     = cur_q;
  assign cur_set_o = set_q;
endmodule

// File: rtl/pef_wave.sv
`timescale 1ns/1ps
module pef_wave
  import pef_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              active_i,
  input  logic              data_i,
  input  logic              drive_i,
  input  logic [TICK_W-1:0] on_i,
  input  logic [TICK_W-1:0] off_i,
  output logic              pin_out,
  output logic              pin_oe
);
  logic held_q;
  logic past_on;
  logic in_win;

  assign past_on = tick_i >= on_i;
  assign in_win  = past_on && (tick_i < off_i);

  // Last driven bit, kept for the part of a non-return-to-zero vector before drive-on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else if (active_i && drive_i && tick_i == on_i) held_q <= data_i;
  end

  always_comb begin
    case (fmt_i)
      FMT_RZ:  pin_out = in_win ? data_i : 1'b0;
      FMT_R1:  pin_out = in_win ? data_i : 1'b1;
      default: pin_out = past_on ? data_i : held_q;
    endcase
  end

  assign pin_oe = active_i && drive_i;
endmodule

// File: rtl/pef_compare.sv
`timescale 1ns/1ps
module pef_compare #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              active_i,
  input  logic [TICK_W-1:0] strobe_i,
  input  logic              exp_i,
  input  logic              mask_i,
  input  logic              pin_in,
  input  logic              clr_i,
  output logic              fail_pulse,
  output logic              fail_sticky
);
  logic hit;

  assign hit = active_i && (tick_i == strobe_i) && !mask_i && (pin_in != exp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_pulse  <= 1'b0;
      fail_sticky <= 1'b0;
    end else begin
      fail_pulse <= hit;
      if (hit)        fail_sticky <= 1'b1;
      else if (clr_i) fail_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_edge_formatter.sv
`timescale 1ns/1ps
module pin_edge_formatter
  import pef_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int NUM_SETS   = 4,
  parameter int MIN_PERIOD = 10,
  parameter int SET_W      = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] period_i,
  input  logic [1:0]        fmt_i,
  input  logic              cfg_we,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [1:0]        cfg_edge,
  input  logic [TICK_W-1:0] cfg_val,
  input  logic              vec_valid,
  output logic              vec_ready,
  input  logic              vec_data,
  input  logic              vec_drive,
  input  logic              vec_exp,
  input  logic              vec_mask,
  input  logic [SET_W-1:0]  vec_set,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  input  logic              fail_clr,
  output logic              fail_pulse,
  output logic              fail_sticky
);
  vec_t              in_vec;
  vec_t              cur_vec;
  logic [TICK_W-1:0] tick_q;
  logic              active_q;
  logic [SET_W-1:0]  cur_set;
  logic [TICK_W-1:0] per_eff;
  logic [TICK_W-1:0] on_t, off_t, strobe_t;

  assign in_vec = '{data: vec_data, drive: vec_drive, exp_v: vec_exp, mask: vec_mask};

  pef_tick_seq #(.TICK_W(TICK_W), .SET_W(SET_W), .MIN_PERIOD(MIN_PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .in_valid(vec_valid), .in_vec(in_vec), .in_set(vec_set), .in_ready(vec_ready),
    .tick_o(tick_q), .active_o(active_q), .cur_o(cur_vec), .cur_set_o(cur_set),
    .per_eff_o(per_eff)
  );

  pef_tset_table #(.TICK_W(TICK_W), .NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_set(cfg_set), .wr_edge(cfg_edge),
    .wr_val(cfg_val), .rd_set(cur_set), .per_eff(per_eff),
    .on_o(on_t), .off_o(off_t), .strobe_o(strobe_t)
  );

  pef_wave #(.TICK_W(TICK_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .tick_i(tick_q), .active_i(active_q),
    .data_i(cur_vec.data), .drive_i(cur_vec.drive), .on_i(on_t), .off_i(off_t),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  pef_compare #(.TICK_W(TICK_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_q), .active_i(active_q), .strobe_i(strobe_t),
    .exp_i(cur_vec.exp_v), .mask_i(cur_vec.mask), .pin_in(pin_in), .clr_i(fail_clr),
    .fail_pulse(fail_pulse), .fail_sticky(fail_sticky)
  );
endmodule

// File: rtl/pef_checker.sv
`timescale 1ns/1ps
module pef_checker #(
  parameter int TICK_W     = 8,
  parameter int MIN_PERIOD = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic              pin_oe,
  input logic              fail_pulse,
  input logic              fail_sticky,
  input logic              fail_clr,
  input logic [TICK_W-1:0] tick,
  input logic              active,
  input logic              cur_drive
);
  localparam logic [TICK_W-1:0] EARLY_LIMIT = TICK_W'(MIN_PERIOD - 1);

  p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick < EARLY_LIMIT) |-> !vec_ready);

  p_accept_tick0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (active && tick == '0));

  p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !vec_ready) |=> (active && tick == $past(tick) + TICK_W'(1)));

  p_sense_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cur_drive) |-> !pin_oe);

  p_idle_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pin_oe);

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !fail_pulse);

  p_pulse_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> fail_sticky);

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_sticky && !fail_clr) |=> fail_sticky);
endmodule

bind pin_edge_formatter pef_checker #(.TICK_W(TICK_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .pin_oe(pin_oe), .fail_pulse(fail_pulse), .fail_sticky(fail_sticky),
  .fail_clr(fail_clr), .tick(tick_q), .active(active_q), .cur_drive(cur_vec.drive)
);

// File: tb/tb_pin_edge_formatter.sv
`timescale 1ns/1ps
module tb_pin_edge_formatter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period_i = 8'd12;
  logic [1:0] fmt_i = 2'd0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_set = '0;
  logic [1:0] cfg_edge = '0;
  logic [7:0] cfg_val = '0;
  logic       vec_valid = 1'b0;
  logic       vec_ready;
  logic       vec_data = 1'b0, vec_drive = 1'b0, vec_exp = 1'b0, vec_mask = 1'b0;
  logic [1:0] vec_set = '0;
  logic       pin_in = 1'b0;
  logic       pin_out, pin_oe;
  logic       fail_clr = 1'b0;
  logic       fail_pulse, fail_sticky;

  int n_chk = 0;
  int n_bad = 0;
  int bt_on [4] = '{0, 0, 0, 0};
  int bt_off[4] = '{0, 0, 0, 0};
  int bt_st [4] = '{0, 0, 0, 0};
  int per_b = 12;
  logic prev_b = 1'b0;
  logic pend_b = 1'b0;

  always #4 clk = ~clk;

  pin_edge_formatter dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .fmt_i(fmt_i),
    .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_edge(cfg_edge), .cfg_val(cfg_val),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
    .vec_drive(vec_drive), .vec_exp(vec_exp), .vec_mask(vec_mask), .vec_set(vec_set),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fail_clr(fail_clr),
    .fail_pulse(fail_pulse), .fail_sticky(fail_sticky)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic int clampf(input int v, input int per);
    return (v >= per) ? per - 1 : v;
  endfunction

  function automatic logic model(input int k, input int on, input int off,
                                 input logic d, input logic prev);
    case (fmt_i)
      2'd1:    return (k >= on && k < off) ? d : 1'b0;
      2'd2:    return (k >= on && k < off) ? d : 1'b1;
      default: return (k >= on) ? d : prev;
    endcase
  endfunction

  function automatic string fmt_tag();
    case (fmt_i)
      2'd1:    return "R3 RZ";
      2'd2:    return "R4 R1";
      default: return "R2 NRZ";
    endcase
  endfunction

  // Called and returns at a falling edge, with the channel idle or on a last tick.
  task automatic wr_edge(input int s, input int e, input int v);
    cfg_we = 1'b1; cfg_set = 2'(s); cfg_edge = 2'(e); cfg_val = 8'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (e == 0) bt_on[s] = v;
    else if (e == 1) bt_off[s] = v;
    else bt_st[s] = v;
  endtask

  task automatic run_vec(input logic d, input logic drv, input logic ev, input logic msk,
                         input int ts, input logic sval, input logic oval, input string tag);
    int per = (per_b < 10) ? 10 : per_b;
    int on  = clampf(bt_on[ts], per);
    int off = clampf(bt_off[ts], per);
    int st  = clampf(bt_st[ts], per);
    logic f = !msk && (sval != ev);
    logic old_pend = pend_b;
    vec_data = d; vec_drive = drv; vec_exp = ev; vec_mask = msk; vec_set = 2'(ts);
    vec_valid = 1'b1;
    while (!vec_ready) @(negedge clk);
    for (int k = 0; k < per; k++) begin
      @(negedge clk);
      if (k == 0) vec_valid = 1'b0;
      pin_in = (k == st) ? sval : oval;
      chk(fail_pulse, (k == 0) ? old_pend : (f && k == st + 1),
          $sformatf("R8 %s tick %0d fail_pulse", tag, k));
      chk(vec_ready, k == per - 1, $sformatf("R7 %s tick %0d vec_ready", tag, k));
      chk(pin_oe, drv, $sformatf("R5 %s tick %0d pin_oe", tag, k));
      if (drv)
        chk(pin_out, model(k, on, off, d, prev_b),
            $sformatf("%s %s tick %0d pin_out", fmt_tag(), tag, k));
    end
    if (drv) prev_b = d;
    pend_b = f && (st == per - 1);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    chk(fail_pulse, pend_b, "R8 idle fail_pulse");
    pend_b = 1'b0;
    chk(pin_oe, 1'b0, "R5 idle pin_oe");
    chk(vec_ready, 1'b1, "R7 idle vec_ready");
  endtask

  task automatic clear_fail();
    fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
    chk(fail_sticky, 1'b0, "R9 sticky cleared by fail_clr");
  endtask

  task automatic t_reset();
    chk(vec_ready, 1'b1, "R12 reset vec_ready");
    chk(pin_oe, 1'b0, "R12 reset pin_oe");
    chk(pin_out, 1'b0, "R12 reset pin_out");
    chk(fail_pulse, 1'b0, "R12 reset fail_pulse");
    chk(fail_sticky, 1'b0, "R12 reset fail_sticky");
    // Zeroed set 3: RZ drive-on = drive-off = 0 gives an empty window.
    fmt_i = 2'd1;
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 3, 1'b0, 1'b0, "R12 zero table");
    idle_cycle();
  endtask

  task automatic t_nrz();
    wr_edge(0, 0, 3); wr_edge(0, 1, 7); wr_edge(0, 2, 5);
    fmt_i = 2'd0;
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 d1");
    run_vec(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 d0");
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 d1 again");
    idle_cycle();
    fmt_i = 2'd3;
    run_vec(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 fmt3");
    idle_cycle();
  endtask

  task automatic t_rz();
    fmt_i = 2'd1;
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R3 d1");
    run_vec(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R3 d0");
    idle_cycle();
  endtask

  task automatic t_r1();
    fmt_i = 2'd2;
    run_vec(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R4 d0");
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R4 d1");
    idle_cycle();
  endtask

  task automatic t_sets();
    wr_edge(1, 0, 1); wr_edge(1, 1, 9); wr_edge(1, 2, 8);
    fmt_i = 2'd1;
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R6 set1");
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R6 set0");
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R6 set1 again");
    idle_cycle();
  endtask

  task automatic t_sense();
    run_vec(1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R5 sense");
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R5 drive after sense");
    idle_cycle();
  endtask

  task automatic t_compare();
    fmt_i = 2'd0;
    run_vec(1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, "R8 match only at strobe");
    chk(fail_sticky, 1'b0, "R8 off-strobe level ignored");
    run_vec(1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b1, "R8 mismatch at strobe");
    chk(fail_sticky, 1'b1, "R9 sticky set by mismatch");
    run_vec(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R9 later match");
    chk(fail_sticky, 1'b1, "R9 sticky holds");
    idle_cycle();
    clear_fail();
  endtask

  task automatic t_mask();
    run_vec(1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R11 masked mismatch");
    chk(fail_sticky, 1'b0, "R11 masked sticky");
    idle_cycle();
  endtask

  task automatic t_clamp();
    wr_edge(2, 0, 2); wr_edge(2, 1, 50); wr_edge(2, 2, 40);
    fmt_i = 2'd1;
    run_vec(1'b1, 1'b1, 1'b1, 1'b0, 2, 1'b0, 1'b1, "R10 clamped edges");
    idle_cycle();
    chk(fail_sticky, 1'b1, "R10 strobe clamped to last tick");
    clear_fail();
  endtask

  task automatic t_period();
    per_b = 4; period_i = 8'd4;
    fmt_i = 2'd1;
    run_vec(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R1 short period floor");
    idle_cycle();
    per_b = 20; period_i = 8'd20;
    run_vec(1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R1 period 20");
    run_vec(1'b0, 1'b0, 1'b1, 1'b0, 1, 1'b1, 1'b0, "R1 period 20 sense");
    idle_cycle();
    chk(fail_sticky, 1'b0, "R1 period 20 no fail");
    per_b = 12; period_i = 8'd12;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nrz();
    t_rz();
    t_r1();
    t_sets();
    t_sense();
    t_compare();
    t_mask();
    t_clamp();
    t_period();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule